// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block keeps a 32-bit record of pending interrupt events next to three 32-bit mask words. All four are reached over a simple word-addressed register bus. Hardware raises an event by pulsing one bit of a 32-bit event input, and that pulse sets the matching cause bit. Software acknowledges events by writing the cause word with zeros in the positions it wants to clear and ones everywhere else. Bit 0 of the cause word is not storage. It is a live flag that is high whenever any of bits 31:1 is pending.

The first mask word gates the cause word onto a single level-sensitive interrupt output. The second and third mask words are held for neighbouring logic and are readable. Each mask keeps only its implemented bits, and the unimplemented bits always read as zero. Reads are combinational from the address and have no side effects.

Top module: `irqc_top`

## Requirements
- R1: After reset the cause word and all three mask words read as zero, and the interrupt output is low.
- R2: A write to the cause word (word offset 0) updates bits 31:1 to their old value AND the written data. A zero clears a bit, a one keeps it, and bit 0 of the written data has no effect.
- R3: Bit 0 of the cause word always reads as the OR of its bits 31:1. This holds after software writes and after hardware sets.
- R4: An event input bit n with n from 1 to 31, high at a clock edge, sets cause bit n. Event input bit 0 has no effect, and no cause bit becomes set without an event.
- R5: When an event sets a cause bit in the same cycle that a cause write clears it, the bit ends up set.
- R6: A write to the main mask (word offset 1) stores the write data AND 0x3C3FFFFE.
- R7: A write to the PCI cause mask (word offset 2) stores the write data AND 0x03FFFFFE.
- R8: A write to the error-report mask (word offset 3) stores the write data AND 0x0000003F.
- R9: The interrupt output is high exactly when some bit in 31:1 is set in both the cause word and the main mask.
- R10: A read returns the addressed word in the same cycle and changes no state. Offsets above 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the offset on reg_addr (combinational) |
| evt_set | input | 32 | Event pulses; bits 31:1 set the matching cause bits |
| irq_out | output | 1 | Masked interrupt request |

## Verification
Read data and the interrupt output follow the registers with no further delay. A write or an event that is present at a rising edge therefore shows up in reg_rdata and irq_out right after that edge. The bench drives its inputs on the falling edge and updates its model at the rising edge. It clears the strobes just after that edge, then reads every offset back, one per nanosecond step, while no write or event is active, so every stored value is compared in the cycle after its update. Address changes are checked combinationally within half a clock period.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW    = 32;
    localparam int NMASK = 3;

    localparam int OFS_CAUSE = 0;
    localparam int OFS_MASK0 = 1;

    localparam logic [DW-1:0] KEEP_MAIN = 32'h3C3F_FFFE;
    localparam logic [DW-1:0] KEEP_PCI  = 32'h03FF_FFFE;
    localparam logic [DW-1:0] KEEP_SERR = 32'h0000_003F;

    function automatic logic [DW-1:0] keep_for(input int idx);
        case (idx)
            0:       return KEEP_MAIN;
            1:       return KEEP_PCI;
            default: return KEEP_SERR;
        endcase
    endfunction

    typedef struct packed {
        logic [DW-1:1] bits;
    } cause_st_t;

    typedef struct packed {
        logic [NMASK-1:0][DW-1:0] val;
    } mask_st_t;
endpackage

// File: rtl/irqc_cause_reg.sv
module irqc_cause_reg
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_we,
    input  logic [DW-1:1] clr_data,
    input  logic [DW-1:1] evt,
    output logic [DW-1:0] cause_word
);
    cause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.bits = st_q.bits & clr_data;
        end
        st_d.bits = st_d.bits | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_word = {st_q.bits, |st_q.bits};
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
    import irqc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NMASK-1:0]          we,
    input  logic [DW-1:0]             wdata,
    output logic [NMASK-1:0][DW-1:0]  masks
);
    mask_st_t st_d, st_q;
    logic [NMASK-1:0][DW-1:0] keep_w;

    for (genvar g = 0; g < NMASK; g++) begin : g_keep
        assign keep_w[g] = keep_for(g);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NMASK; i++) begin
            if (we[i]) begin
                st_d.val[i] = wdata & keep_w[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign masks = st_q.val;
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DW-1:0]             cause_word,
    input  logic [NMASK-1:0][DW-1:0]  masks,
    output logic [DW-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CAUSE)) begin
            rdata = cause_word;
        end
        for (int i = 0; i < NMASK; i++) begin
            if (addr == ADDR_W'(OFS_MASK0 + i)) begin
                rdata = masks[i];
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       evt_set,
    output logic              irq_out
);
    logic                     wr_cause;
    logic [NMASK-1:0]         wr_mask;
    logic [DW-1:0]            cause_word;
    logic [NMASK-1:0][DW-1:0] masks;
    logic [DW-1:0]            mask_main;
    logic [DW-1:0]            mask_pci;
    logic [DW-1:0]            mask_serr;
    logic                     unused_evt0;

    assign unused_evt0 = evt_set[0];
    assign wr_cause    = reg_wr && (reg_addr == ADDR_W'(OFS_CAUSE));

    for (genvar g = 0; g < NMASK; g++) begin : g_wdec
        assign wr_mask[g] = reg_wr && (reg_addr == ADDR_W'(OFS_MASK0 + g));
    end

    irqc_cause_reg u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_we     (wr_cause),
        .clr_data   (reg_wdata[DW-1:1]),
        .evt        (evt_set[DW-1:1]),
        .cause_word (cause_word)
    );

    irqc_mask_bank u_masks (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_mask),
        .wdata (reg_wdata),
        .masks (masks)
    );

    irqc_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr       (reg_addr),
        .cause_word (cause_word),
        .masks      (masks),
        .rdata      (reg_rdata)
    );

    assign mask_main = masks[0];
    assign mask_pci  = masks[1];
    assign mask_serr = masks[2];

    assign irq_out = |(cause_word[DW-1:1] & mask_main[DW-1:1]);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [31:0]       evt_set,
    input logic              irq_out,
    input logic [31:0]       cause_word,
    input logic [31:0]       mask_main,
    input logic [31:0]       mask_pci,
    input logic [31:0]       mask_serr
);
    AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CAUSE) && evt_set[31:1] == '0)
        |=> (cause_word[31:1] == ($past(cause_word[31:1]) & $past(reg_wdata[31:1])))); // R2

    AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_CAUSE)) |-> (reg_rdata[0] == (|reg_rdata[31:1]))); // R3

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_word[31:1] & ~$past(cause_word[31:1]) & ~$past(evt_set[31:1])) == '0)); // R4

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[31:1] != '0)
        |=> ((cause_word[31:1] & $past(evt_set[31:1])) == $past(evt_set[31:1]))); // R5

    AST_MAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_main & ~KEEP_MAIN) == '0); // R6

    AST_PCI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_pci & ~KEEP_PCI) == '0); // R7

    AST_SERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_serr & ~KEEP_SERR) == '0); // R8

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_main == '0 || cause_word[31:1] == '0) |-> !irq_out); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(OFS_MASK0 + NMASK - 1)) |-> (reg_rdata == '0)); // R10
endmodule

bind irqc_top irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_set    (evt_set),
    .irq_out    (irq_out),
    .cause_word (cause_word),
    .mask_main  (mask_main),
    .mask_pci   (mask_pci),
    .mask_serr  (mask_serr)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb_top;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [31:0]       evt_set = '0;
    logic              irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_cause = '0;
    logic [31:0] m_main  = '0;
    logic [31:0] m_pci   = '0;
    logic [31:0] m_serr  = '0;

    always #(CLK_P/2) clk = ~clk;

    irqc_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_set   (evt_set),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] cause_view(input logic [31:0] c);
        return {c[31:1], |c[31:1]};
    endfunction

    function automatic logic [31:0] next_cause(input logic [31:0] c, input bit wr,
                                               input logic [31:0] d, input logic [31:0] e);
        logic [31:0] r;
        r = wr ? (c & d) : c;
        r = r | e;
        r[0] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_set = e;
        @(posedge clk);
        m_cause = next_cause(m_cause, wr && a == 0, d, e);
        if (wr && a == 1) m_main = d & 32'h3C3F_FFFE;
        if (wr && a == 2) m_pci  = d & 32'h03FF_FFFE;
        if (wr && a == 3) m_serr = d & 32'h0000_003F;
        #1;
        reg_wr = 1'b0; evt_set = '0;
    endtask

    task automatic read_all(input string tag);
        reg_addr = 4'd0; #1; chk({tag, " R2 R3 cause"}, reg_rdata, cause_view(m_cause));
        reg_addr = 4'd1; #1; chk({tag, " R6 main mask"}, reg_rdata, m_main);
        reg_addr = 4'd2; #1; chk({tag, " R7 pci mask"}, reg_rdata, m_pci);
        reg_addr = 4'd3; #1; chk({tag, " R8 serr mask"}, reg_rdata, m_serr);
        chk({tag, " R9 irq"}, {31'd0, irq_out}, {31'd0, |(m_cause[31:1] & m_main[31:1])});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 reset");

        // R4: event bit 0 ignored; bit 5 sets
        step(1'b0, 4'd0, '0, 32'h0000_0001);
        read_all("R4 evt bit0");
        step(1'b0, 4'd0, '0, 32'h0000_0020);
        read_all("R4 evt bit5 R3");

        // R9: enable main mask, irq rises
        step(1'b1, 4'd1, 32'hFFFF_FFFF, '0);
        read_all("R9 mask all");

        // R2: bit0 of write data ignored, zero clears
        step(1'b0, 4'd0, '0, 32'h8000_0040);
        step(1'b1, 4'd0, 32'hFFFF_FFBF, '0);
        read_all("R2 clear one");

        // R5: set and clear same bit same cycle
        step(1'b1, 4'd0, 32'h0000_0000, 32'h0000_0100);
        read_all("R5 set wins");

        // R10: unmapped write and read
        step(1'b1, 4'd9, 32'hFFFF_FFFF, '0);
        read_all("R10 unmapped write");
        reg_addr = 4'd12; #1;
        chk("R10 unmapped read", reg_rdata, 32'h0);

        // R6 R7 R8 all-ones
        step(1'b1, 4'd2, 32'hFFFF_FFFF, '0);
        step(1'b1, 4'd3, 32'hFFFF_FFFF, '0);
        read_all("R7 R8 all ones");

        // R9: mask off masks interrupt
        step(1'b1, 4'd1, 32'h0000_0000, '0);
        read_all("R9 mask off");

        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d, e;
            a = ADDR_W'($urandom_range(0, 5));
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
            e = $urandom() & $urandom() & $urandom();
            if ($urandom_range(0, 2) == 0) e = '0;
            step($urandom_range(0, 1) == 1, a, d, e);
            read_all("rand");
        end

        // R3: clear everything, summary drops
        step(1'b1, 4'd0, 32'h0000_0000, '0);
        read_all("R3 all clear");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule